// File: doc/BRIEF.md
# Low-Power Stop Mode Controller

This block decides what a small microcontroller does when its CPU issues a stop request. It then sequences entry into one of two stop depths and the exit from them. When the request arrives, five configuration bits are read through a fixed priority. The result is one of five outcomes: a refused request that raises an illegal-opcode reset, a shallow stop that keeps internal clocks alive for debugging, a shallow stop with the regulator fully on, a shallow stop with the regulator in standby, or a deep stop that powers down the main domain.

The controller is a Moore machine. A combinational selector maps the configuration to a target state. A state register holds `ST_RUN`, `ST_DBG`, `ST_REGON`, `ST_STBY`, `ST_DEEP` or `ST_DEXIT`, and registered outputs are decoded from the next state. The transitions are:
- enter: `ST_RUN` to the selected stop state on `stop_req`;
- refuse: `ST_RUN` stays in `ST_RUN` and pulses `illegal_rst`;
- shallow wake: `ST_DBG`, `ST_REGON` or `ST_STBY` back to `ST_RUN`;
- deep wake: `ST_DEEP` to `ST_DEXIT`;
- restart: `ST_DEXIT` to `ST_RUN`.

Power-on reset returns the machine to `ST_RUN` from any state.

The deep stop freezes the I/O pin control state. After a deep wake the pins stay frozen until software acknowledges through `io_release`. A sticky flag records that the last restart came from the deep stop.

Top module: `stopmode_ctrl`

## Requirements
- R1: If `cfg_stop_en` is 0 when `stop_req` is sampled in `ST_RUN`, the controller stays running (clock enables stay 1). `illegal_rst` is 1 for exactly the one cycle after that edge.
- R2: With `cfg_stop_en`=1 and `cfg_dbg_en`=1, a stop request enters the debug stop, whatever the other bits are. In it both clock enables are 0, `reg_mode`=00 and `refclk_keep`=1.
- R3: With `cfg_dbg_en`=0 and both `cfg_lvd_en` and `cfg_lvd_stop_en` set to 1, a stop request enters the regulator-on stop. In it both clock enables are 0, `reg_mode`=00 and `refclk_keep` equals `cfg_clk_keep`.
- R4: With `cfg_dbg_en`=0, either LVD bit at 0 and `cfg_deep_sel`=0, a stop request enters the standby stop. In it both clock enables are 0, `reg_mode`=01 and `refclk_keep` equals `cfg_clk_keep`.
- R5: With `cfg_dbg_en`=0, either LVD bit at 0 and `cfg_deep_sel`=1, a stop request enters the deep stop. In it both clock enables are 0, `reg_mode`=10, `dom_off`=1 and `refclk_keep`=0.
- R6: All outputs take their stop-state values at the clock edge that samples `stop_req`.
- R7: `io_hold` rises on entry to the deep stop. It stays 1 through the stop and the restart, and clears only when `io_release` is 1 while running. `io_release` in any other state has no effect.
- R8: The deep stop is left only by `wake_rst_pin`, `wake_irq_pin`, `rtc_irq` or power-on reset. `irq_pend` alone leaves it in place.
- R9: A deep wake produces one cycle with `wake_rst`=1, clock enables still 0, `dom_off`=0 and `reg_mode`=00. Running resumes on the next cycle. `deep_wake_flag` sets with the wake and clears only on `io_release` while running, or on power-on reset.
- R10: A shallow stop is left by `irq_pend` or any wake pin or `rtc_irq`. The clock enables return to 1 at the edge that samples the wake, and `wake_rst` stays 0.
- R11: `stop_req` while in any stop state changes no output.
- R12: `por_n` low returns all outputs to their running values, with `io_hold` and `deep_wake_flag` at 0.
- R13: `reg_mode` never shows the code 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| stop_req | input | 1 | Stop request strobe from the CPU |
| cfg_stop_en | input | 1 | Stop modes permitted |
| cfg_dbg_en | input | 1 | Debug active, keep internal clocks |
| cfg_lvd_en | input | 1 | Low-voltage detect enabled |
| cfg_lvd_stop_en | input | 1 | Low-voltage detect kept on in stop |
| cfg_deep_sel | input | 1 | Choose the deep stop over standby |
| cfg_clk_keep | input | 1 | Keep reference clocks in shallow stop |
| irq_pend | input | 1 | Any enabled interrupt pending |
| wake_rst_pin | input | 1 | Reset-capable wake pin asserted |
| wake_irq_pin | input | 1 | External-interrupt wake pin asserted |
| rtc_irq | input | 1 | Real-time-clock interrupt |
| io_release | input | 1 | Software acknowledge that frees the pins |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| bus_clk_en | output | 1 | Bus clock gate enable |
| reg_mode | output | 2 | Regulator code: 00 active, 01 standby, 10 partial power-down |
| refclk_keep | output | 1 | Reference clocks kept running |
| io_hold | output | 1 | I/O pin control state frozen |
| dom_off | output | 1 | Main power domain switched off |
| illegal_rst | output | 1 | One-cycle illegal-opcode reset |
| wake_rst | output | 1 | One-cycle restart after deep wake |
| deep_wake_flag | output | 1 | Sticky: last restart came from the deep stop |

## Verification
A wrong state shows at the ports on the very next cycle, because every output is registered from the next state. A misdecoded stop target appears as a wrong `reg_mode`, `dom_off` or `refclk_keep` straight after the request. A missing restart state shows up as a missing `wake_rst` cycle, or as clocks returning one cycle early. A stuck hold or flag register becomes visible only once software would have released it, so the bench reads these after the restart, after an ignored acknowledge and after a valid one.

// File: rtl/stopmode_pkg.sv
package stopmode_pkg;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_DBG   = 3'd1,
        ST_REGON = 3'd2,
        ST_STBY  = 3'd3,
        ST_DEEP  = 3'd4,
        ST_DEXIT = 3'd5
    } state_t;

    localparam int REG_W = 2;
    localparam logic [REG_W-1:0] REG_ACTIVE = 2'b00;
    localparam logic [REG_W-1:0] REG_STBY   = 2'b01;
    localparam logic [REG_W-1:0] REG_PPD    = 2'b10;

    typedef struct packed {
        logic stop_en;
        logic dbg_en;
        logic lvd_en;
        logic lvd_stop_en;
        logic deep_sel;
    } cfg_t;

endpackage

// File: rtl/stopmode_select.sv
module stopmode_select
    import stopmode_pkg::*;
(
    input  cfg_t   cfg,
    output state_t target
);
    // Fixed priority: refusal, debug, regulator-on, then standby or deep.
    always_comb begin
        if (!cfg.stop_en)
            target = ST_RUN;
        else if (cfg.dbg_en)
            target = ST_DBG;
        else if (cfg.lvd_en && cfg.lvd_stop_en)
            target = ST_REGON;
        else if (cfg.deep_sel)
            target = ST_DEEP;
        else
            target = ST_STBY;
    end
endmodule

// File: rtl/stopmode_fsm.sv
module stopmode_fsm
    import stopmode_pkg::*;
(
    input  logic   clk,
    input  logic   por_n,
    input  logic   stop_req,
    input  state_t target,
    input  logic   wake_shallow,
    input  logic   wake_deep,
    output state_t state_q,
    output state_t state_d,
    output logic   illegal_hit
);
    always_comb begin
        state_d     = state_q;
        illegal_hit = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (stop_req) begin
                    if (target == ST_RUN)
                        illegal_hit = 1'b1;
                    else
                        state_d = target;
                end
            end
            ST_DBG, ST_REGON, ST_STBY: begin
                if (wake_shallow)
                    state_d = ST_RUN;
            end
            ST_DEEP: begin
                if (wake_deep)
                    state_d = ST_DEXIT;
            end
            ST_DEXIT: state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            state_q <= ST_RUN;
        else
            state_q <= state_d;
    end

    // R1: a refused request leaves the machine running
    a_r1_stay_run: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_RUN && stop_req && target == ST_RUN) |=> state_q == ST_RUN);

    // R8: without a deep wake source the deep stop persists
    a_r8_deep_hold: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_DEEP && !wake_deep) |=> state_q == ST_DEEP);

    // R11: shallow stop ignores requests until woken
    a_r11_shallow_stable: assert property (@(posedge clk) disable iff (!por_n)
        ((state_q == ST_DBG || state_q == ST_REGON || state_q == ST_STBY) && !wake_shallow)
        |=> state_q == $past(state_q));

    // R9: restart state lasts one cycle
    a_r9_dexit_once: assert property (@(posedge clk) disable iff (!por_n)
        state_q == ST_DEXIT |=> state_q == ST_RUN);
endmodule

// File: rtl/stopmode_outdec.sv
module stopmode_outdec
    import stopmode_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  state_t           state_q,
    input  state_t           state_d,
    input  logic             illegal_hit,
    input  logic             clk_keep,
    input  logic             io_release,
    output logic             cpu_clk_en,
    output logic             bus_clk_en,
    output logic [REG_W-1:0] reg_mode,
    output logic             refclk_keep,
    output logic             io_hold,
    output logic             dom_off,
    output logic             illegal_rst,
    output logic             wake_rst,
    output logic             deep_wake_flag
);
    logic             run_n;
    logic [REG_W-1:0] reg_n;
    logic             ref_n;

    always_comb begin
        run_n = 1'b0;
        reg_n = REG_ACTIVE;
        ref_n = 1'b1;
        unique case (state_d)
            ST_RUN:   run_n = 1'b1;
            ST_DBG:   ref_n = 1'b1;
            ST_REGON: ref_n = clk_keep;
            ST_STBY: begin
                reg_n = REG_STBY;
                ref_n = clk_keep;
            end
            ST_DEEP: begin
                reg_n = REG_PPD;
                ref_n = 1'b0;
            end
            ST_DEXIT: ref_n = 1'b1;
            default:  run_n = 1'b1;
        endcase
    end

    logic release_ok;
    assign release_ok = (state_q == ST_RUN) && io_release;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cpu_clk_en     <= 1'b1;
            bus_clk_en     <= 1'b1;
            reg_mode       <= REG_ACTIVE;
            refclk_keep    <= 1'b1;
            dom_off        <= 1'b0;
            illegal_rst    <= 1'b0;
            wake_rst       <= 1'b0;
            io_hold        <= 1'b0;
            deep_wake_flag <= 1'b0;
        end else begin
            cpu_clk_en  <= run_n;
            bus_clk_en  <= run_n;
            reg_mode    <= reg_n;
            refclk_keep <= ref_n;
            dom_off     <= (state_d == ST_DEEP);
            illegal_rst <= illegal_hit;
            wake_rst    <= (state_d == ST_DEXIT);
            if (state_d == ST_DEEP)
                io_hold <= 1'b1;
            else if (release_ok)
                io_hold <= 1'b0;
            if (state_d == ST_DEXIT)
                deep_wake_flag <= 1'b1;
            else if (release_ok)
                deep_wake_flag <= 1'b0;
        end
    end

    // R1: the illegal-opcode reset never lasts two cycles
    a_r1_one_cycle: assert property (@(posedge clk) disable iff (!por_n)
        illegal_rst |=> !illegal_rst);

    // R13: the reserved regulator code never appears
    a_r13_code_legal: assert property (@(posedge clk) disable iff (!por_n)
        reg_mode != 2'b11);

    // R7: the domain is never off while the pins are free
    a_r7_hold_in_deep: assert property (@(posedge clk) disable iff (!por_n)
        dom_off |-> io_hold);

    // R9: the deep-wake flag stays set until acknowledged while running
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!por_n)
        (deep_wake_flag && !release_ok) |=> deep_wake_flag);
endmodule

// File: rtl/stopmode_ctrl.sv
module stopmode_ctrl
    import stopmode_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       stop_req,
    input  logic       cfg_stop_en,
    input  logic       cfg_dbg_en,
    input  logic       cfg_lvd_en,
    input  logic       cfg_lvd_stop_en,
    input  logic       cfg_deep_sel,
    input  logic       cfg_clk_keep,
    input  logic       irq_pend,
    input  logic       wake_rst_pin,
    input  logic       wake_irq_pin,
    input  logic       rtc_irq,
    input  logic       io_release,
    output logic       cpu_clk_en,
    output logic       bus_clk_en,
    output logic [1:0] reg_mode,
    output logic       refclk_keep,
    output logic       io_hold,
    output logic       dom_off,
    output logic       illegal_rst,
    output logic       wake_rst,
    output logic       deep_wake_flag
);
    cfg_t   cfg;
    state_t target;
    state_t state_q;
    state_t state_d;
    logic   illegal_hit;
    logic   wake_deep;
    logic   wake_shallow;

    assign cfg = '{stop_en: cfg_stop_en, dbg_en: cfg_dbg_en, lvd_en: cfg_lvd_en,
                   lvd_stop_en: cfg_lvd_stop_en, deep_sel: cfg_deep_sel};

    assign wake_deep    = wake_rst_pin | wake_irq_pin | rtc_irq;
    assign wake_shallow = wake_deep | irq_pend;

    stopmode_select u_sel (
        .cfg    (cfg),
        .target (target)
    );

    stopmode_fsm u_fsm (
        .clk          (clk),
        .por_n        (por_n),
        .stop_req     (stop_req),
        .target       (target),
        .wake_shallow (wake_shallow),
        .wake_deep    (wake_deep),
        .state_q      (state_q),
        .state_d      (state_d),
        .illegal_hit  (illegal_hit)
    );

    stopmode_outdec u_out (
        .clk            (clk),
        .por_n          (por_n),
        .state_q        (state_q),
        .state_d        (state_d),
        .illegal_hit    (illegal_hit),
        .clk_keep       (cfg_clk_keep),
        .io_release     (io_release),
        .cpu_clk_en     (cpu_clk_en),
        .bus_clk_en     (bus_clk_en),
        .reg_mode       (reg_mode),
        .refclk_keep    (refclk_keep),
        .io_hold        (io_hold),
        .dom_off        (dom_off),
        .illegal_rst    (illegal_rst),
        .wake_rst       (wake_rst),
        .deep_wake_flag (deep_wake_flag)
    );

    // R5: both clock gates agree at every cycle
    a_r5_gates_agree: assert property (@(posedge clk) disable iff (!por_n)
        cpu_clk_en == bus_clk_en);

    // R10: clocks never restart straight out of the deep stop
    a_r10_no_direct_deep_exit: assert property (@(posedge clk) disable iff (!por_n)
        dom_off |=> !cpu_clk_en);
endmodule

// File: tb/stopmode_ctrl_test.sv
module stopmode_ctrl_test;
    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic stop_req = 0, cfg_stop_en = 0, cfg_dbg_en = 0, cfg_lvd_en = 0;
    logic cfg_lvd_stop_en = 0, cfg_deep_sel = 0, cfg_clk_keep = 0;
    logic irq_pend = 0, wake_rst_pin = 0, wake_irq_pin = 0, rtc_irq = 0, io_release = 0;
    logic       cpu_clk_en, bus_clk_en, refclk_keep, io_hold, dom_off;
    logic       illegal_rst, wake_rst, deep_wake_flag;
    logic [1:0] reg_mode;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    stopmode_ctrl uut (
        .clk(clk), .por_n(por_n), .stop_req(stop_req),
        .cfg_stop_en(cfg_stop_en), .cfg_dbg_en(cfg_dbg_en), .cfg_lvd_en(cfg_lvd_en),
        .cfg_lvd_stop_en(cfg_lvd_stop_en), .cfg_deep_sel(cfg_deep_sel),
        .cfg_clk_keep(cfg_clk_keep), .irq_pend(irq_pend), .wake_rst_pin(wake_rst_pin),
        .wake_irq_pin(wake_irq_pin), .rtc_irq(rtc_irq), .io_release(io_release),
        .cpu_clk_en(cpu_clk_en), .bus_clk_en(bus_clk_en), .reg_mode(reg_mode),
        .refclk_keep(refclk_keep), .io_hold(io_hold), .dom_off(dom_off),
        .illegal_rst(illegal_rst), .wake_rst(wake_rst), .deep_wake_flag(deep_wake_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Outputs are checked at the falling edge, inputs driven there too.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Expected stop outcome: 0 refuse, 1 debug, 2 reg-on, 3 standby, 4 deep
    function automatic int exp_mode(input int c);
        if (((c >> 4) & 1) == 0) return 0;
        if (((c >> 3) & 1) == 1) return 1;
        if (((c >> 2) & 1) == 1 && ((c >> 1) & 1) == 1) return 2;
        if ((c & 1) == 1) return 4;
        return 3;
    endfunction

    task automatic chk_stop(input string req, input int m, input int keep);
        int er;
        int ek;
        er = (m == 3) ? 1 : (m == 4) ? 2 : 0;
        ek = (m == 1) ? 1 : (m == 4) ? 0 : keep;
        chk({req, " cpu_clk_en"}, cpu_clk_en, 0);
        chk({req, " bus_clk_en"}, bus_clk_en, 0);
        chk({req, " reg_mode"}, reg_mode, er);
        chk({req, " refclk_keep"}, refclk_keep, ek);
        chk({req, " dom_off"}, dom_off, (m == 4) ? 1 : 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R12: reset state
        chk("R12 reset cpu_clk_en", cpu_clk_en, 1);
        chk("R12 reset reg_mode", reg_mode, 0);
        chk("R12 reset io_hold", io_hold, 0);
        chk("R12 reset flag", deep_wake_flag, 0);
        por_n = 1'b1;
        step();

        for (int idx = 0; idx < 64; idx++) begin
            int c;
            int m;
            int keep;
            c = idx & 31;
            keep = idx >> 5;
            m = exp_mode(c);
            {cfg_stop_en, cfg_dbg_en, cfg_lvd_en, cfg_lvd_stop_en, cfg_deep_sel} = c[4:0];
            cfg_clk_keep = keep[0];
            stop_req = 1;
            step();
            stop_req = 0;
            if (m == 0) begin
                chk("R1 illegal_rst pulse", illegal_rst, 1);
                chk("R1 clocks stay on", cpu_clk_en, 1);
                step();
                chk("R1 pulse one cycle", illegal_rst, 0);
                chk("R1 still running", cpu_clk_en, 1);
            end else begin
                string tag;
                tag = (m == 1) ? "R2" : (m == 2) ? "R3" : (m == 3) ? "R4" : "R5";
                chk_stop({tag, " R6 entry"}, m, keep);
                chk("R7 hold on entry", io_hold, (m == 4) ? 1 : 0);
                stop_req = 1;
                step();
                stop_req = 0;
                chk_stop("R11 request ignored", m, keep);
                if (m == 4) begin
                    irq_pend = 1;
                    step();
                    irq_pend = 0;
                    chk("R8 irq_pend no deep exit", dom_off, 1);
                    chk("R8 irq_pend no restart", wake_rst, 0);
                    io_release = 1;
                    step();
                    io_release = 0;
                    chk("R7 release ignored in stop", io_hold, 1);
                end
                case (idx % 4)
                    0: rtc_irq = 1;
                    1: wake_irq_pin = 1;
                    2: wake_rst_pin = 1;
                    default: if (m == 4) rtc_irq = 1; else irq_pend = 1;
                endcase
                step();
                {rtc_irq, wake_irq_pin, wake_rst_pin, irq_pend} = 4'b0;
                if (m == 4) begin
                    chk("R9 wake_rst pulse", wake_rst, 1);
                    chk("R9 clocks still gated", cpu_clk_en, 0);
                    chk("R9 domain back on", dom_off, 0);
                    chk("R9 regulator active", reg_mode, 0);
                    chk("R9 flag set", deep_wake_flag, 1);
                    step();
                    chk("R9 running after restart", cpu_clk_en, 1);
                    chk("R9 pulse one cycle", wake_rst, 0);
                    chk("R7 hold kept after restart", io_hold, 1);
                    step();
                    chk("R9 flag sticky", deep_wake_flag, 1);
                    io_release = 1;
                    step();
                    io_release = 0;
                    chk("R7 hold released", io_hold, 0);
                    chk("R9 flag cleared", deep_wake_flag, 0);
                end else begin
                    chk("R10 clocks back", cpu_clk_en, 1);
                    chk("R10 bus back", bus_clk_en, 1);
                    chk("R10 no restart", wake_rst, 0);
                    chk("R10 regulator active", reg_mode, 0);
                end
                chk("R13 code legal", (reg_mode == 2'b11) ? 1 : 0, 0);
            end
        end

        // R12: power-on reset during the deep stop
        {cfg_stop_en, cfg_dbg_en, cfg_lvd_en, cfg_lvd_stop_en, cfg_deep_sel} = 5'b10001;
        stop_req = 1;
        step();
        stop_req = 0;
        chk("R5 deep before reset", dom_off, 1);
        por_n = 0;
        #1;
        chk("R12 por clocks on", cpu_clk_en, 1);
        chk("R12 por domain on", dom_off, 0);
        chk("R12 por hold clear", io_hold, 0);
        chk("R12 por flag clear", deep_wake_flag, 0);
        step();
        por_n = 1;
        step();
        chk("R12 running after por", cpu_clk_en, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule